// File: doc/BRIEF.md
# Pulse-Width Remote Control Decoder

The block takes an already synchronised remote-control input and times the interval between successive measured edges, rising by default or falling when selected, with a 16-bit cycle counter. Each interval is sorted into one of several symbols by comparing it against programmable inclusive windows: header, data zero, data one and special. Data symbols are packed least-significant-bit first into a 48-bit receive buffer. The first eight received bits are compared against a reference byte under a per-bit mask.

A frame ends when the counter runs past the largest of the three maximum limits with no new edge. The decoder then drops to idle, and the next edge only restarts timing. Nine event sources each set a sticky request flag when their enable bit is 1. A request line is the OR of all flags, and a flag is cleared by writing 1 to its position. A small write-only register port loads the windows, the mode bits, the enables and the compare settings.

Top module: `irdec_top`

## Requirements
- R1: After reset, all flags, the request line, the bit count, the receive buffer and the captured width are zero.
- R2: While active, a measured edge copies the number of clock cycles since the previous measured edge into the capture output and raises the measurement event (flag bit 7). An edge seen while idle only starts timing and raises no event.
- R3: A width with header-min <= width <= header-max raises the header event (bit 0) when header detection is on, and either the header has not yet been seen or special detection is off. It clears the bit count and the buffer. Header wins over an overlapping data window.
- R4: A width inside the data-0 window (checked first) or the data-1 window raises the data event (bit 1) and stores 0 or 1 at buffer position equal to the current count, then increments the count.
- R5: With special detection on and the header already seen, a width in the header window raises the special event (bit 2) and leaves the count and the buffer unchanged.
- R6: A width in no window, or a data symbol before any header while header detection is on, raises the error event (bit 3) and clears the count and the header-seen state.
- R7: When the counter exceeds max(header-max, data0-max, data1-max) with no edge, the completion event (bit 4) is raised, the count and header-seen state clear, and the block goes idle.
- R8: The full event (bit 5) is raised when the count reaches 48. Further data symbols still raise bit 1 but change neither the count nor the buffer.
- R9: When the eighth bit is stored, the compare event (bit 6) is raised if buffer bits [7:0] equal the compare value in every position where the compare mask is 1.
- R10: While active, the counter wraps from FFFFh to 0000h and raises the overflow event (bit 8).
- R11: A flag is set only when its enable bit is 1, and the request output is the OR of all flags.
- R12: Writing 1 to a flag position at address 9 clears that flag. A set and a clear of the same flag in the same cycle leave it set.
- R13: Register addresses: 0 header-min, 1 header-max, 2 data0-min, 3 data0-max, 4 data1-min, 5 data1-max. Address 6 holds the mode: bit 0 selects the falling edge, bit 1 enables header detection, bit 2 enables special detection. Address 7 holds the event enables [8:0]. Address 8 holds the compare value [7:0] and mask [15:8]. Address 9 is flag clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_in | input | 1 | Synchronised remote-control input |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration register address |
| cfg_wdata | input | 16 | Configuration write data |
| evt_flags | output | 9 | Sticky event request flags |
| irq | output | 1 | OR of all flags |
| rx_data | output | 48 | Receive buffer |
| rx_count | output | 6 | Number of stored bits |
| cap_width | output | 16 | Last captured width |

## Verification
Two cases put functions in the same cycle. In the first, a flag-clear write lands on the exact clock edge where the measurement event sets that flag. The bench issues the clear write at the negative edge on which it drives the closing input edge, and requires the flag to read back as set. In the second, the eighth and the forty-eighth stored bits each raise two events at once: data with compare, then data with full. The bench requires the exact combined flag pattern after each of those edges.

// File: rtl/irdec_pkg.sv
package irdec_pkg;
  localparam int CNT_W    = 16;
  localparam int BUF_BITS = 48;
  localparam int BCNT_W   = $clog2(BUF_BITS + 1);
  localparam int CMP_W    = 8;
  localparam int ADDR_W   = 4;
  localparam int EVT_N    = 9;

  localparam logic [ADDR_W-1:0] A_HMIN = 4'd0;
  localparam logic [ADDR_W-1:0] A_HMAX = 4'd1;
  localparam logic [ADDR_W-1:0] A_ZMIN = 4'd2;
  localparam logic [ADDR_W-1:0] A_ZMAX = 4'd3;
  localparam logic [ADDR_W-1:0] A_OMIN = 4'd4;
  localparam logic [ADDR_W-1:0] A_OMAX = 4'd5;
  localparam logic [ADDR_W-1:0] A_MODE = 4'd6;
  localparam logic [ADDR_W-1:0] A_ENAB = 4'd7;
  localparam logic [ADDR_W-1:0] A_CMPR = 4'd8;
  localparam logic [ADDR_W-1:0] A_CLR  = 4'd9;

  typedef enum int {
    EV_HDR = 0, EV_DATA = 1, EV_SPEC = 2, EV_ERR = 3, EV_DONE = 4,
    EV_FULL = 5, EV_CMP = 6, EV_MEAS = 7, EV_OVF = 8
  } evt_idx_e;

  typedef struct packed {
    logic [CNT_W-1:0] h_min;
    logic [CNT_W-1:0] h_max;
    logic [CNT_W-1:0] z_min;
    logic [CNT_W-1:0] z_max;
    logic [CNT_W-1:0] o_min;
    logic [CNT_W-1:0] o_max;
    logic             edge_fall;
    logic             hdr_en;
    logic             spec_en;
    logic [EVT_N-1:0] evt_en;
    logic [CMP_W-1:0] cmp_val;
    logic [CMP_W-1:0] cmp_mask;
  } cfg_t;

  function automatic logic [CNT_W-1:0] max3(input logic [CNT_W-1:0] a,
                                            input logic [CNT_W-1:0] b,
                                            input logic [CNT_W-1:0] c);
    logic [CNT_W-1:0] m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/irdec_cfg.sv
module irdec_cfg
  import irdec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       wdata,
  input  logic [EVT_N-1:0]  evt_set,
  output cfg_t              cfg,
  output logic [EVT_N-1:0]  flags
);
  cfg_t             cfg_q, cfg_d;
  logic [EVT_N-1:0] flags_q, flags_d, clr_v, set_v;

  always_comb begin
    cfg_d = cfg_q;
    if (we) begin
      case (addr)
        A_HMIN: cfg_d.h_min = wdata[CNT_W-1:0];
        A_HMAX: cfg_d.h_max = wdata[CNT_W-1:0];
        A_ZMIN: cfg_d.z_min = wdata[CNT_W-1:0];
        A_ZMAX: cfg_d.z_max = wdata[CNT_W-1:0];
        A_OMIN: cfg_d.o_min = wdata[CNT_W-1:0];
        A_OMAX: cfg_d.o_max = wdata[CNT_W-1:0];
        A_MODE: begin
          cfg_d.edge_fall = wdata[0];
          cfg_d.hdr_en    = wdata[1];
          cfg_d.spec_en   = wdata[2];
        end
        A_ENAB: cfg_d.evt_en = wdata[EVT_N-1:0];
        A_CMPR: begin
          cfg_d.cmp_val  = wdata[CMP_W-1:0];
          cfg_d.cmp_mask = wdata[2*CMP_W-1:CMP_W];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    clr_v   = (we && addr == A_CLR) ? wdata[EVT_N-1:0] : '0;
    set_v   = evt_set & cfg_q.evt_en;
    flags_d = (flags_q & ~clr_v) | set_v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      flags_q <= '0;
    end else begin
      cfg_q   <= cfg_d;
      flags_q <= flags_d;
    end
  end

  assign cfg   = cfg_q;
  assign flags = flags_q;

  // R12: a request raised in a cycle is visible next cycle, even under a clear
  assert_set_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (|(evt_set & cfg.evt_en)) |=> ((flags & $past(evt_set & cfg.evt_en)) == $past(evt_set & cfg.evt_en)));
  // R11: a disabled source never sets its flag
  assert_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!we) |=> ((flags & ~$past(flags)) == (flags & ~$past(flags) & $past(cfg.evt_en))));
endmodule

// File: rtl/irdec_timer.sv
module irdec_timer
  import irdec_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_in,
  input  logic             edge_fall,
  input  logic [CNT_W-1:0] limit,
  output logic             meas,
  output logic [CNT_W-1:0] width,
  output logic [CNT_W-1:0] cap,
  output logic             evt_done,
  output logic             evt_ovf
);
  logic             rx_prev_q, active_q, active_d, edge_hit;
  logic [CNT_W-1:0] cnt_q, cnt_d, cap_q, cap_d;

  assign edge_hit = edge_fall ? (rx_prev_q & ~rx_in) : (~rx_prev_q & rx_in);

  always_comb begin
    active_d = active_q;
    cnt_d    = cnt_q;
    cap_d    = cap_q;
    meas     = 1'b0;
    evt_done = 1'b0;
    evt_ovf  = 1'b0;
    if (edge_hit) begin
      if (active_q) begin
        meas  = 1'b1;
        cap_d = cnt_q;
      end
      active_d = 1'b1;
      cnt_d    = {{(CNT_W-1){1'b0}}, 1'b1};
    end else if (active_q) begin
      if (cnt_q > limit) begin
        evt_done = 1'b1;
        active_d = 1'b0;
        cnt_d    = '0;
      end else begin
        cnt_d   = cnt_q + 1'b1;
        evt_ovf = (cnt_q == {CNT_W{1'b1}});
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_prev_q <= 1'b0;
      active_q  <= 1'b0;
      cnt_q     <= '0;
      cap_q     <= '0;
    end else begin
      rx_prev_q <= rx_in;
      active_q  <= active_d;
      cnt_q     <= cnt_d;
      cap_q     <= cap_d;
    end
  end

  assign width = cnt_q;
  assign cap   = cap_q;

  // R2: the captured width only moves on a measured edge
  assert_cap_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !meas |=> $stable(cap));
  // R7: completion leaves the timer idle
  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    evt_done |=> (!active_q && width == '0));
  // R10: a wrap restarts the count from zero
  assert_wrap_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    evt_ovf |=> (width == '0));
endmodule

// File: rtl/irdec_frame.sv
module irdec_frame
  import irdec_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                meas,
  input  logic                done,
  input  logic [CNT_W-1:0]    width,
  input  cfg_t                cfg,
  output logic                evt_hdr,
  output logic                evt_data,
  output logic                evt_spec,
  output logic                evt_err,
  output logic                evt_full,
  output logic                evt_cmp,
  output logic [BUF_BITS-1:0] data,
  output logic [BCNT_W-1:0]   count
);
  typedef enum logic [1:0] {SYM_HDR, SYM_SPEC, SYM_DATA, SYM_ERR} sym_e;

  logic [BUF_BITS-1:0] data_q, data_d;
  logic [BCNT_W-1:0]   cnt_q, cnt_d;
  logic                seen_q, seen_d, in_h, in_z, in_o, bit_v;
  sym_e                sym;

  always_comb begin
    in_h  = (width >= cfg.h_min) && (width <= cfg.h_max);
    in_z  = (width >= cfg.z_min) && (width <= cfg.z_max);
    in_o  = (width >= cfg.o_min) && (width <= cfg.o_max);
    bit_v = !in_z;
    if (in_h && cfg.hdr_en && (!seen_q || !cfg.spec_en)) sym = SYM_HDR;
    else if (in_h && cfg.spec_en)                        sym = SYM_SPEC;
    else if ((in_z || in_o) && !(cfg.hdr_en && !seen_q)) sym = SYM_DATA;
    else                                                 sym = SYM_ERR;
  end

  always_comb begin
    data_d   = data_q;
    cnt_d    = cnt_q;
    seen_d   = seen_q;
    evt_hdr  = 1'b0;
    evt_data = 1'b0;
    evt_spec = 1'b0;
    evt_err  = 1'b0;
    evt_full = 1'b0;
    evt_cmp  = 1'b0;
    if (done) begin
      cnt_d  = '0;
      seen_d = 1'b0;
    end else if (meas) begin
      case (sym)
        SYM_HDR: begin
          evt_hdr = 1'b1;
          seen_d  = 1'b1;
          cnt_d   = '0;
          data_d  = '0;
        end
        SYM_SPEC: evt_spec = 1'b1;
        SYM_DATA: begin
          evt_data = 1'b1;
          if (cnt_q < BCNT_W'(BUF_BITS)) begin
            data_d[cnt_q] = bit_v;
            cnt_d         = cnt_q + 1'b1;
            evt_full      = (cnt_q == BCNT_W'(BUF_BITS - 1));
            evt_cmp       = (cnt_q == BCNT_W'(CMP_W - 1)) &&
                            (((data_d[CMP_W-1:0] ^ cfg.cmp_val) & cfg.cmp_mask) == '0);
          end
        end
        default: begin
          evt_err = 1'b1;
          cnt_d   = '0;
          seen_d  = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      cnt_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      data_q <= data_d;
      cnt_q  <= cnt_d;
      seen_q <= seen_d;
    end
  end

  assign data  = data_q;
  assign count = cnt_q;

  // R8: the bit count never passes the buffer size
  assert_count_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    count <= BCNT_W'(BUF_BITS));
  // R8: the full event leaves exactly a full buffer
  assert_full_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
    evt_full |=> (count == BCNT_W'(BUF_BITS)));
  // R6: an error restarts the frame
  assert_err_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    evt_err |=> (count == '0 && !seen_q));
  // R5: a special symbol leaves the stored bits alone
  assert_spec_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
    evt_spec |=> ($stable(count) && $stable(data)));
endmodule

// File: rtl/irdec_top.sv
module irdec_top
  import irdec_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rx_in,
  input  logic                cfg_we,
  input  logic [ADDR_W-1:0]   cfg_addr,
  input  logic [15:0]         cfg_wdata,
  output logic [EVT_N-1:0]    evt_flags,
  output logic                irq,
  output logic [BUF_BITS-1:0] rx_data,
  output logic [BCNT_W-1:0]   rx_count,
  output logic [CNT_W-1:0]    cap_width
);
  cfg_t             cfg;
  logic [EVT_N-1:0] evt_set;
  logic             meas, t_done, t_ovf;
  logic             f_hdr, f_data, f_spec, f_err, f_full, f_cmp;
  logic [CNT_W-1:0] width, limit;

  assign limit = max3(cfg.h_max, cfg.z_max, cfg.o_max);

  irdec_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .evt_set(evt_set), .cfg(cfg), .flags(evt_flags)
  );

  irdec_timer u_timer (
    .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .edge_fall(cfg.edge_fall),
    .limit(limit), .meas(meas), .width(width), .cap(cap_width),
    .evt_done(t_done), .evt_ovf(t_ovf)
  );

  irdec_frame u_frame (
    .clk(clk), .rst_n(rst_n), .meas(meas), .done(t_done), .width(width),
    .cfg(cfg), .evt_hdr(f_hdr), .evt_data(f_data), .evt_spec(f_spec),
    .evt_err(f_err), .evt_full(f_full), .evt_cmp(f_cmp),
    .data(rx_data), .count(rx_count)
  );

  always_comb begin
    evt_set          = '0;
    evt_set[EV_HDR]  = f_hdr;
    evt_set[EV_DATA] = f_data;
    evt_set[EV_SPEC] = f_spec;
    evt_set[EV_ERR]  = f_err;
    evt_set[EV_DONE] = t_done;
    evt_set[EV_FULL] = f_full;
    evt_set[EV_CMP]  = f_cmp;
    evt_set[EV_MEAS] = meas;
    evt_set[EV_OVF]  = t_ovf;
  end

  assign irq = |evt_flags;

  // R1: the request line tracks the flags
  assert_irq_or_R1: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (evt_flags != '0));
endmodule

// File: tb/tb_irdec_top.sv
module tb_irdec_top;
  logic        clk, rst_n, rx_in, cfg_we;
  logic [3:0]  cfg_addr;
  logic [15:0] cfg_wdata;
  logic [8:0]  evt_flags;
  logic        irq;
  logic [47:0] rx_data;
  logic [5:0]  rx_count;
  logic [15:0] cap_width;
  int          n_chk, n_bad;

  irdec_top dut (
    .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .evt_flags(evt_flags),
    .irq(irq), .rx_data(rx_data), .rx_count(rx_count), .cap_width(cap_width)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // vector: width, expected flags, expected count
  localparam int NV = 11;
  localparam logic [30:0] VEC [NV] = '{
    {16'd12, 9'h088, 6'd0}, {16'd45, 9'h081, 6'd0}, {16'd10, 9'h082, 6'd1},
    {16'd24, 9'h082, 6'd2}, {16'd14, 9'h082, 6'd3}, {16'd17, 9'h088, 6'd0},
    {16'd40, 9'h081, 6'd0}, {16'd20, 9'h082, 6'd1}, {16'd50, 9'h081, 6'd0},
    {16'd51, 9'h088, 6'd0}, {16'd9,  9'h088, 6'd0}
  };

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // called one negedge after a measured rising edge; closes a width of n cycles
  task automatic meas(input int n, input bit clr_same);
    rx_in = 1'b0;
    cfg_we = 1'b1; cfg_addr = 4'd9; cfg_wdata = 16'h01FF;
    @(negedge clk);
    cfg_we = 1'b0;
    repeat (n - 2) @(negedge clk);
    rx_in = 1'b1;
    if (clr_same) begin
      cfg_we = 1'b1; cfg_addr = 4'd9; cfg_wdata = 16'h0080;
    end
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // let the frame time out, then start timing again from idle
  task automatic resync();
    repeat (60) @(negedge clk);
    meas(20, 1'b0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    logic [47:0] exp_buf;
    n_chk = 0; n_bad = 0;
    rst_n = 1'b0; rx_in = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 flags", evt_flags, 0);
    chk("R1 irq", irq, 0);
    chk("R1 count", rx_count, 0);
    chk("R1 data", rx_data, 0);
    chk("R1 cap", cap_width, 0);

    // R13 register map
    wr(4'd0, 16'd40); wr(4'd1, 16'd50);
    wr(4'd2, 16'd10); wr(4'd3, 16'd14);
    wr(4'd4, 16'd20); wr(4'd5, 16'd24);
    wr(4'd6, 16'h0002); wr(4'd7, 16'h01FF); wr(4'd8, 16'hF0A5);

    rx_in = 1'b1;
    @(negedge clk);
    chk("R2 idle first edge", evt_flags, 0);

    for (int k = 0; k < NV; k++) begin
      meas(int'(VEC[k][30:15]), 1'b0);
      chk("R3/R4/R6 table flags", evt_flags, VEC[k][14:6]);
      chk("R4 table count", rx_count, VEC[k][5:0]);
      chk("R2 table capture", cap_width, VEC[k][30:15]);
      if (k == 4) chk("R4 bit order", rx_data, 48'h2);
    end

    // R7 completion by timeout, then idle
    meas(45, 1'b0);
    meas(22, 1'b0);
    repeat (60) @(negedge clk);
    chk("R7 done flag", evt_flags[4], 1);
    chk("R7 count cleared", rx_count, 0);
    meas(20, 1'b0);
    chk("R7 idle restart", evt_flags, 0);

    // R11 enables
    wr(4'd7, 16'h01FE);
    resync();
    meas(45, 1'b0);
    chk("R11 header masked", evt_flags, 9'h080);
    chk("R11 irq", irq, 1);
    meas(22, 1'b0);
    chk("R11 data after masked header", evt_flags, 9'h082);
    wr(4'd7, 16'h0000);
    resync();
    meas(45, 1'b0);
    chk("R11 all masked", evt_flags, 0);
    chk("R11 irq low", irq, 0);
    wr(4'd7, 16'h01FF);

    // R5 special symbol
    wr(4'd6, 16'h0006);
    resync();
    meas(45, 1'b0);
    meas(22, 1'b0);
    meas(45, 1'b0);
    chk("R5 special flags", evt_flags, 9'h084);
    chk("R5 count kept", rx_count, 1);
    chk("R5 data kept", rx_data, 48'h1);

    // R3 header wins an overlap
    wr(4'd6, 16'h0002); wr(4'd2, 16'd30); wr(4'd3, 16'd45);
    resync();
    meas(42, 1'b0);
    chk("R3 overlap header", evt_flags, 9'h081);
    wr(4'd2, 16'd10); wr(4'd3, 16'd14);

    // R8 / R9 full buffer and masked compare
    resync();
    meas(45, 1'b0);
    exp_buf = '0;
    for (int i = 0; i < 48; i++) begin
      bit b;
      b = (i < 8) ? bit'((8'hAC >> i) & 1) : bit'(((i * 5) >> 1) & 1);
      exp_buf[i] = b;
      meas(b ? 22 : 12, 1'b0);
      if (i == 7) chk("R9 compare match", evt_flags, 9'h0C2);
      else if (i == 47) chk("R8 full", evt_flags, 9'h0A2);
      else if (i == 20) chk("R4 plain data", evt_flags, 9'h082);
    end
    chk("R8 count 48", rx_count, 48);
    chk("R8 buffer", rx_data, exp_buf);
    meas(22, 1'b0);
    chk("R8 extra flagged", evt_flags, 9'h082);
    chk("R8 extra count", rx_count, 48);
    chk("R8 extra dropped", rx_data, exp_buf);

    meas(45, 1'b0);
    for (int i = 0; i < 8; i++) meas(((8'h3C >> i) & 1) != 0 ? 22 : 12, 1'b0);
    chk("R9 masked mismatch", evt_flags, 9'h082);

    // R12 clear and set in the same cycle
    meas(12, 1'b1);
    chk("R12 set wins", evt_flags, 9'h082);
    wr(4'd9, 16'h0002);
    chk("R12 write-one clear", evt_flags, 9'h080);

    // R10 counter wrap
    wr(4'd1, 16'hFFFF); wr(4'd3, 16'hFFFF); wr(4'd5, 16'hFFFF);
    wr(4'd9, 16'h01FF);
    repeat (65545) @(negedge clk);
    chk("R10 overflow", evt_flags, 9'h100);
    summary();
  end
endmodule